// File: doc/BRIEF.md
# Four-Channel Counter/Timer

This block holds four independent 8-bit down-counting channels behind a small byte-wide CPU port. A two-bit select on that port picks one channel. A write goes either to that channel's control word or to its time constant. A read always returns the live value of the selected down-counter.

Each channel runs in one of two modes:
- **Timer mode:** the channel counts system clocks through a prescaler that divides by 16 or by 256. It starts either as soon as the time constant is loaded or on a chosen edge of its trigger input.
- **Counter mode:** the channel counts the chosen edge (rising or falling) of its trigger input.

When a counter passes through zero, it reloads from its time constant. Channels 0 to 2 then give a one-clock pulse on their zero-count output. A channel with interrupts enabled latches a pending flag. A fixed-priority request output names the lowest-numbered pending channel, and an acknowledge strobe clears that channel's flag.

Top module: `quad_tick_timer`

## Requirements
- R1: After reset every counter reads 0, no channel runs, `irq_req` is 0 and `zc_pulse` is 0.
- R2: A write with data bit 0 = 1 is a control word. Its fields are: bit 7 interrupt enable; bit 6 mode (1 counter, 0 timer); bit 5 prescale (1 divide by 256, 0 divide by 16); bit 4 edge (1 rising, 0 falling); bit 3 timer waits for a trigger edge; bit 2 a time constant follows; bit 1 soft reset.
- R3: The write that follows a control word with bit 2 set loads the time constant and the counter. The new value is readable on `bus_rdata` in the next cycle.
- R4: A running timer decrements once every 16 or 256 clocks, as bit 5 selects. The first decrement comes 16 (or 256) clocks after the load.
- R5: When a decrement takes the counter from 1, the counter reloads the time constant. `zc_pulse[i]` is high for exactly one clock on channels 0 to 2; channel 3 has no such output.
- R6: In counter mode, each selected edge of `ext_trig[i]` decrements the counter. The opposite edge has no effect.
- R7: In timer mode with bit 3 set, the counter holds after the load until the selected trigger edge arrives. The first decrement follows 16 (or 256) clocks later.
- R8: A time constant of 0 counts 256 events per period.
- R9: A control word with bit 1 set stops the channel. The counter then holds until a new time constant is written.
- R10: A zero count sets the channel's pending flag only when bit 7 is set. `irq_ack` clears the flag of the channel shown on `irq_chan`.
- R11: `irq_req` is high while any flag is pending. `irq_chan` shows the lowest-numbered pending channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one clock |
| bus_sel | input | 2 | Channel select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Current counter of the selected channel |
| ext_trig | input | 4 | Per-channel trigger / count input |
| zc_pulse | output | 3 | Zero-count pulses, channels 0 to 2 |
| irq_req | output | 1 | Some channel has an interrupt pending |
| irq_chan | output | 2 | Highest-priority pending channel |
| irq_ack | input | 1 | Clears the pending flag of `irq_chan` |

## Verification
The bench samples the counter exactly on the clock where the first prescaled decrement should land, and one clock before it. A prescaler that is off by one therefore fails, as does one that ignores the 16/256 choice.

It drives the edge the counter must ignore, and checks that a timer armed for a trigger holds still until that trigger arrives. A time constant of 0 must run a full 256 events, not stop or wrap at once. A soft reset must freeze the counter.

The interrupt checks set two flags in the same cycle, and include a channel with interrupts disabled. They then acknowledge one flag at a time. An inverted priority, an acknowledge that clears the wrong channel, or a flag set while disabled all show up in `irq_chan` or `irq_req`.

// File: rtl/quad_tick_timer.sv
module quad_tick_timer #(
  parameter int PS_LO = 16,
  parameter int PS_HI = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic [1:0] bus_sel,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [3:0] ext_trig,
  output logic [2:0] zc_pulse,
  output logic       irq_req,
  output logic [1:0] irq_chan,
  input  logic       irq_ack
);
  localparam logic [7:0] LAST_LO = 8'(PS_LO - 1);
  localparam logic [7:0] LAST_HI = 8'(PS_HI - 1);

  logic [3:0][7:0] cnt, tc, pre, ctl;
  logic [3:0] run_q, armed, tc_pend, pend, trig_q, zc_q;
  logic [3:0] edge_hit, tick, hit;

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      edge_hit[i] = ctl[i][4] ? (ext_trig[i] & ~trig_q[i]) : (~ext_trig[i] & trig_q[i]);
      tick[i]     = run_q[i] & (ctl[i][6] ? edge_hit[i]
                                          : (pre[i] == (ctl[i][5] ? LAST_HI : LAST_LO)));
      hit[i]      = tick[i] & (cnt[i] == 8'd1);
    end
  end

  always_comb begin
    irq_chan = 2'd0;
    for (int i = 3; i >= 0; i--)
      if (pend[i]) irq_chan = 2'(i);
  end

  assign irq_req   = |pend;
  assign bus_rdata = cnt[bus_sel];
  assign zc_pulse  = zc_q[2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; tc <= '0; pre <= '0; ctl <= '0;
      run_q <= '0; armed <= '0; tc_pend <= '0; pend <= '0;
      trig_q <= '0; zc_q <= '0;
    end else begin
      trig_q <= ext_trig;
      for (int i = 0; i < 4; i++) begin
        zc_q[i] <= hit[i];
        if (hit[i] && ctl[i][7])                 pend[i] <= 1'b1;
        else if (irq_ack && irq_chan == 2'(i))   pend[i] <= 1'b0;

        if (bus_wr && bus_sel == 2'(i)) begin
          if (tc_pend[i]) begin
            tc[i]      <= bus_wdata;
            cnt[i]     <= bus_wdata;
            pre[i]     <= '0;
            tc_pend[i] <= 1'b0;
            armed[i]   <= ctl[i][3] & ~ctl[i][6];
            run_q[i]   <= ~(ctl[i][3] & ~ctl[i][6]);
          end else if (bus_wdata[0]) begin
            ctl[i]     <= bus_wdata;
            tc_pend[i] <= bus_wdata[2];
            if (bus_wdata[1]) begin
              run_q[i] <= 1'b0;
              armed[i] <= 1'b0;
            end
          end
        end else begin
          if (armed[i] && edge_hit[i]) begin
            armed[i] <= 1'b0;
            run_q[i] <= 1'b1;
          end
          if (run_q[i]) begin
            pre[i] <= (tick[i] || ctl[i][6]) ? 8'd0 : pre[i] + 8'd1;
            if (tick[i]) cnt[i] <= hit[i] ? tc[i] : cnt[i] - 8'd1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/quad_tick_timer_chk.sv
module quad_tick_timer_chk (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic [1:0]      bus_sel,
  input logic [7:0]      bus_wdata,
  input logic            irq_ack,
  input logic            irq_req,
  input logic [1:0]      irq_chan,
  input logic [2:0]      zc_pulse,
  input logic [3:0][7:0] cnt,
  input logic [3:0]      run_q,
  input logic [3:0]      pend,
  input logic [3:0]      tc_pend
);
  for (genvar i = 0; i < 4; i++) begin : g_ch
    p_stopped_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q[i] && !bus_wr) |=> cnt[i] == $past(cnt[i]));
    p_tc_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_sel == 2'(i) && tc_pend[i]) |=> cnt[i] == $past(bus_wdata));
  end
  for (genvar i = 0; i < 3; i++) begin : g_zc
    p_zc_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      zc_pulse[i] |=> !zc_pulse[i]);
  end
  p_irq_prio_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (pend[irq_chan] && ((pend & ((4'b1 << irq_chan) - 4'b1)) == 4'b0)));
  p_irq_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == 4'b0) |-> !irq_req);
endmodule

bind quad_tick_timer quad_tick_timer_chk chk (.*);

// File: tb/tb_quad_tick_timer.sv
`timescale 1ns/1ps
module tb_quad_tick_timer;
  logic       clk = 0, rst_n = 0, bus_wr = 0, irq_ack = 0;
  logic [1:0] bus_sel = 0;
  logic [7:0] bus_wdata = 0;
  logic [3:0] ext_trig = 0;
  logic [7:0] bus_rdata;
  logic [2:0] zc_pulse;
  logic       irq_req;
  logic [1:0] irq_chan;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  quad_tick_timer dut (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int ch, logic [7:0] d);
    bus_sel = 2'(ch); bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(int ch, output int v);
    bus_sel = 2'(ch); #1 v = bus_rdata;
  endtask

  task automatic pulse(int ch);
    ext_trig[ch] = 1; cyc(1);
    ext_trig[ch] = 0; cyc(1);
  endtask

  task automatic t_reset;
    int v;
    for (int c = 0; c < 4; c++) begin rd(c, v); chk("R1 counter", v, 0); end
    chk("R1 irq_req", irq_req, 0);
    chk("R1 zc", zc_pulse, 0);
  endtask

  task automatic t_timer16;
    int v, v2;
    wr(0, 8'h05); wr(0, 8'd3);
    rd(0, v); chk("R3 load readable", v, 3);
    cyc(15); rd(0, v); chk("R4 before first tick", v, 3);
    cyc(1);  rd(0, v); chk("R4 first tick /16", v, 2);
    cyc(32); rd(0, v); chk("R5 reload", v, 3);
    chk("R5 zc0 high", zc_pulse[0], 1);
    chk("R10 no irq when disabled", irq_req, 0);
    cyc(1); chk("R5 zc0 one clock", zc_pulse[0], 0);
    wr(0, 8'h03); rd(0, v);
    cyc(40); rd(0, v2); chk("R9 stopped holds", v2, v);
    wr(0, 8'h04); cyc(20); rd(0, v2);
    chk("R2 bit0=0 word ignored", v2, v);
  endtask

  task automatic t_ps256;
    int v;
    wr(1, 8'h25); wr(1, 8'd2);
    cyc(255); rd(1, v); chk("R4 /256 before tick", v, 2);
    cyc(1);   rd(1, v); chk("R4 /256 tick", v, 1);
    wr(1, 8'h03);
  endtask

  task automatic t_counter;
    int v;
    wr(2, 8'h55); wr(2, 8'd2);
    ext_trig[2] = 1; cyc(1); rd(2, v); chk("R6 rising counts", v, 1);
    ext_trig[2] = 0; cyc(1); rd(2, v); chk("R6 falling ignored", v, 1);
    ext_trig[2] = 1; cyc(1); rd(2, v); chk("R5 counter reload", v, 2);
    chk("R5 zc2 high", zc_pulse[2], 1);
    wr(2, 8'h45); wr(2, 8'd5);
    ext_trig[2] = 0; cyc(1); rd(2, v); chk("R6 falling counts", v, 4);
    ext_trig[2] = 1; cyc(1); rd(2, v); chk("R6 rising ignored", v, 4);
    ext_trig[2] = 0; cyc(1);
  endtask

  task automatic t_trigger;
    int v;
    wr(3, 8'h0D); wr(3, 8'd4);
    cyc(40); rd(3, v); chk("R7 waits for trigger", v, 4);
    ext_trig[3] = 1; cyc(20); rd(3, v); chk("R7 wrong edge no start", v, 4);
    ext_trig[3] = 0;
    cyc(16); rd(3, v); chk("R7 before first tick", v, 4);
    cyc(1);  rd(3, v); chk("R7 first tick after trigger", v, 3);
    wr(3, 8'h03);
  endtask

  task automatic t_tc0;
    int v;
    wr(2, 8'h55); wr(2, 8'd0);
    rd(2, v); chk("R8 reads 0", v, 0);
    pulse(2); rd(2, v); chk("R8 wraps to 255", v, 255);
    for (int k = 0; k < 254; k++) pulse(2);
    rd(2, v); chk("R8 one before end", v, 1);
    ext_trig[2] = 1; cyc(1); rd(2, v);
    chk("R8 reload to 0", v, 0);
    chk("R8 zc at 256th", zc_pulse[2], 1);
    ext_trig[2] = 0; cyc(1);
    wr(2, 8'h03);
  endtask

  task automatic t_irq;
    wr(1, 8'hD5); wr(1, 8'd1);
    wr(2, 8'h55); wr(2, 8'd1);
    wr(3, 8'hD5); wr(3, 8'd1);
    ext_trig[3:1] = 3'b111; cyc(1);
    chk("R10 irq raised", irq_req, 1);
    chk("R11 lowest first", irq_chan, 1);
    irq_ack = 1; cyc(1); irq_ack = 0;
    chk("R11 next channel", irq_chan, 3);
    chk("R10 disabled ch2 not pending", irq_req, 1);
    irq_ack = 1; cyc(1); irq_ack = 0;
    chk("R10 ack clears", irq_req, 0);
    ext_trig[3:1] = 3'b000; cyc(1);
  endtask

  initial begin
    #200000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(3); t_reset();
    rst_n = 1; cyc(1);
    t_reset();
    t_timer16();
    t_ps256();
    t_counter();
    t_trigger();
    t_tc0();
    t_irq();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule